// File: doc/BRIEF.md
# Block-Scheduled Matrix Stream Sequencer

This block drives the operand traffic for a linear array of multiply-accumulate processing elements computing C = A×B on square N×N matrices. It walks the result matrix in SI×SJ tiles: row tiles form the outer loop and column tiles the inner loop. For every tile it sends the array a clear command. For each k it then reads SI words from column k of A and SJ words from row k of B from memory and forwards them as one tagged stream. When the tile's operands have all been accepted, it issues the tile's SI×SJ write-back addresses.

Reads use a synchronous memory port with one cycle of latency. A two-entry queue sits between that port and the valid/ready operand stream, so backpressure never drops a word. Write-back runs in its own walker. While one tile is being unloaded, streaming of the next tile may start, provided the array reports that its other result bank is free. A single `start` pulse runs the whole matrix, and `done` pulses once after the final write-back has been accepted.

Top module: `blk_matmul_seq`

## Requirements
- R1: After reset, `op_valid`, `wb_valid`, `rd_en`, `acc_clr` and `done` are all low.
- R2: Each tile gets exactly one `acc_clr` pulse. The pulse comes after every operand of the previous tile has been accepted and before the tile's first operand, and the operand stream is empty while it is high.
- R3: For each k, the stream first carries SI A-words with `op_is_b`=0, read from row-major address (ti·SI+r)·N+k for r = 0..SI−1, where ti is the row-tile index.
- R4: Following those A-words, the stream carries SJ B-words with `op_is_b`=1, read from address k·N+tj·SJ+c for c = 0..SJ−1, where tj is the column-tile index. k runs from 0 to N−1.
- R5: Tiles are visited with the column-tile index varying fastest, for (N/SI)·(N/SJ) tiles in total.
- R6: A tile's write-back addresses (ti·SI+r)·N+tj·SJ+c are issued row-major (c fastest), all below N·N, and only after every operand of that tile has been accepted.
- R7: While `op_valid` is high and `op_ready` is low, `op_valid`, `op_data` and `op_is_b` hold.
- R8: While `wb_valid` is high and `wb_ready` is low, `wb_valid` and `wb_addr` hold.
- R9: A clear is issued only while `bank_free` is high, and nothing is streamed while it is withheld. With `bank_free` high, the next tile's operands may flow while the previous tile is still unloading.
- R10: `done` is a single-cycle pulse that follows acceptance of the last write-back of the last tile.
- R11: Each tile moves SI·N + SJ·N operand words and SI·SJ write-back addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a full matrix pass (accepted while idle) |
| bank_free | input | 1 | Array has a free accumulator bank for a new tile |
| rd_en | output | 1 | Memory read request |
| rd_sel_b | output | 1 | Read targets B (1) or A (0) |
| rd_addr | output | AW | Row-major read address |
| rd_data | input | DW | Read data, one cycle after `rd_en` |
| op_valid | output | 1 | Operand word available |
| op_ready | input | 1 | Array accepts operand word |
| op_is_b | output | 1 | Operand tag: 1 = B element, 0 = A element |
| op_data | output | DW | Operand word |
| acc_clr | output | 1 | Clear the tile accumulators |
| wb_valid | output | 1 | Write-back address valid |
| wb_ready | input | 1 | Write-back accepted |
| wb_addr | output | AW | Row-major address in C |
| done | output | 1 | Pulse after the last write-back |

## Verification
Whole-matrix passes run under several handshake patterns: operand and write-back ready held high, both toggled at different duty cycles, and `bank_free` gated on and off. The free-running pass confirms the nominal address order and tile walk. The sparse-ready passes show whether words are dropped, duplicated or reordered across the one-cycle read latency. The gated pass shows that a tile's clear and operands wait for a free bank, and the slow write-back passes show that the next tile's streaming overlaps the previous unload. A directed pass then holds `bank_free` low after `start` to confirm that nothing is cleared or read.

// File: rtl/blk_matmul_seq.sv
module blk_matmul_seq #(
  parameter int N  = 6,
  parameter int SI = 3,
  parameter int SJ = 2,
  parameter int DW = 64,
  localparam int AW = $clog2(N*N),
  localparam int CW = $clog2(N+1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          bank_free,
  output logic          rd_en,
  output logic          rd_sel_b,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  output logic          op_valid,
  input  logic          op_ready,
  output logic          op_is_b,
  output logic [DW-1:0] op_data,
  output logic          acc_clr,
  output logic          wb_valid,
  input  logic          wb_ready,
  output logic [AW-1:0] wb_addr,
  output logic          done
);
  localparam int NBI = N / SI;
  localparam int NBJ = N / SJ;

  typedef enum logic [1:0] {ST_IDLE, ST_CLR, ST_RUN, ST_DRAIN} st_t;
  st_t st;

  logic [CW-1:0] bi, bj, k, idx;
  logic          ph_b;

  logic [DW-1:0] f_data [2];
  logic          f_tag  [2];
  logic [1:0]    f_cnt;
  logic          infl, infl_b;

  logic          ubusy, ulast, done_q;
  logic [CW-1:0] ubi, ubj, ur, uc;

  logic pop, push, room, drained, last_blk, hand, wb_fire;

  assign op_valid = f_cnt != 2'd0;
  assign op_data  = f_data[0];
  assign op_is_b  = f_tag[0];
  assign pop      = op_valid && op_ready;
  assign push     = infl;
  assign room     = (int'(f_cnt) + int'(infl) - int'(pop)) < 2;
  assign drained  = (f_cnt == 2'd0) && !infl;
  assign last_blk = (bi == CW'(NBI-1)) && (bj == CW'(NBJ-1));
  assign hand     = (st == ST_DRAIN) && drained && !ubusy;
  assign acc_clr  = (st == ST_CLR) && bank_free;

  assign rd_en    = (st == ST_RUN) && room;
  assign rd_sel_b = ph_b;
  assign rd_addr  = ph_b ? AW'(int'(k)*N + int'(bj)*SJ + int'(idx))
                         : AW'((int'(bi)*SI + int'(idx))*N + int'(k));

  assign wb_valid = ubusy;
  assign wb_fire  = ubusy && wb_ready;
  assign wb_addr  = AW'((int'(ubi)*SI + int'(ur))*N + int'(ubj)*SJ + int'(uc));
  assign done     = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE; bi <= '0; bj <= '0; k <= '0; idx <= '0; ph_b <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin st <= ST_CLR; bi <= '0; bj <= '0; end
        ST_CLR:  if (bank_free) begin st <= ST_RUN; k <= '0; idx <= '0; ph_b <= 1'b0; end
        ST_RUN:  if (rd_en) begin
          if (!ph_b) begin
            if (idx == CW'(SI-1)) begin idx <= '0; ph_b <= 1'b1; end
            else idx <= idx + 1'b1;
          end else if (idx == CW'(SJ-1)) begin
            idx <= '0; ph_b <= 1'b0;
            if (k == CW'(N-1)) begin k <= '0; st <= ST_DRAIN; end
            else k <= k + 1'b1;
          end else idx <= idx + 1'b1;
        end
        ST_DRAIN: if (hand) begin
          if (last_blk) st <= ST_IDLE;
          else begin
            st <= ST_CLR;
            if (bj == CW'(NBJ-1)) begin bj <= '0; bi <= bi + 1'b1; end
            else bj <= bj + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      infl <= 1'b0; infl_b <= 1'b0; f_cnt <= '0;
      f_data[0] <= '0; f_data[1] <= '0; f_tag[0] <= 1'b0; f_tag[1] <= 1'b0;
    end else begin
      infl   <= rd_en;
      infl_b <= rd_sel_b;
      case ({push, pop})
        2'b10: begin
          f_data[f_cnt[0]] <= rd_data; f_tag[f_cnt[0]] <= infl_b; f_cnt <= f_cnt + 1'b1;
        end
        2'b01: begin
          f_data[0] <= f_data[1]; f_tag[0] <= f_tag[1]; f_cnt <= f_cnt - 1'b1;
        end
        2'b11: begin
          if (f_cnt == 2'd1) begin f_data[0] <= rd_data; f_tag[0] <= infl_b; end
          else begin
            f_data[0] <= f_data[1]; f_tag[0] <= f_tag[1];
            f_data[1] <= rd_data;   f_tag[1] <= infl_b;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ubusy <= 1'b0; ulast <= 1'b0; done_q <= 1'b0;
      ubi <= '0; ubj <= '0; ur <= '0; uc <= '0;
    end else begin
      done_q <= 1'b0;
      if (hand) begin
        ubusy <= 1'b1; ulast <= last_blk; ubi <= bi; ubj <= bj; ur <= '0; uc <= '0;
      end else if (wb_fire) begin
        if (uc == CW'(SJ-1)) begin
          uc <= '0;
          if (ur == CW'(SI-1)) begin ur <= '0; ubusy <= 1'b0; done_q <= ulast; end
          else ur <= ur + 1'b1;
        end else uc <= uc + 1'b1;
      end
    end
  end

  assert_op_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !op_ready |=> op_valid && $stable(op_data) && $stable(op_is_b));
  assert_wb_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_addr));
  assert_clr_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_clr |-> bank_free);
  assert_clr_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_clr |-> !op_valid);
  assert_rd_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> rd_addr < AW'(N*N-1) || rd_addr == AW'(N*N-1));
  assert_wb_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> wb_addr < AW'(N*N-1) || wb_addr == AW'(N*N-1));
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/test_blk_matmul_seq.sv
module test_blk_matmul_seq;
  localparam int CLK_T = 10;
  localparam int N = 6, SI = 3, SJ = 2, DW = 16;
  localparam int AW = $clog2(N*N);
  localparam int NBJ = N / SJ;
  localparam int NB = (N/SI) * NBJ;
  localparam int NP = 4;
  // {ov_expected, bank_free mask, wb_ready mask, op_ready mask}, bit = cycle % 8
  localparam logic [24:0] PAT [NP] = '{
    {1'b1, 8'hFF, 8'hFF, 8'hFF},
    {1'b1, 8'hFF, 8'h33, 8'hA5},
    {1'b1, 8'hFF, 8'h11, 8'hFF},
    {1'b0, 8'h0F, 8'hFF, 8'h6D}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, bank_free = 1'b0;
  logic op_ready = 1'b0, wb_ready = 1'b0;
  logic rd_en, rd_sel_b, op_valid, op_is_b, acc_clr, wb_valid, done;
  logic [AW-1:0] rd_addr, wb_addr;
  logic [DW-1:0] rd_data = '0, op_data;
  int n_chk = 0, n_fail = 0;

  always #(CLK_T/2) clk = ~clk;

  always @(posedge clk)
    if (rd_en) rd_data <= rd_sel_b ? DW'(1000 + int'(rd_addr)) : DW'(rd_addr);

  blk_matmul_seq #(.N(N), .SI(SI), .SJ(SJ), .DW(DW)) i_blk_matmul_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .bank_free(bank_free),
    .rd_en(rd_en), .rd_sel_b(rd_sel_b), .rd_addr(rd_addr), .rd_data(rd_data),
    .op_valid(op_valid), .op_ready(op_ready), .op_is_b(op_is_b), .op_data(op_data),
    .acc_clr(acc_clr), .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr),
    .done(done));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_job(input logic [24:0] p);
    int eblk = 0, ek = 0, eidx = 0, wblk = 0, wr = 0, wc = 0;
    int n_op = 0, n_wb = 0, n_clr = 0, n_done = 0, tail = -1;
    bit eph = 0, ovl = 0;
    for (int cyc = 0; cyc < 5000; cyc++) begin
      @(negedge clk);
      op_ready  = p[cyc % 8];
      wb_ready  = p[8 + cyc % 8];
      bank_free = p[16 + cyc % 8];
      start     = (cyc == 0);
      #1;
      if (acc_clr) begin
        check(n_clr == eblk && ek == 0 && !eph && eidx == 0, "R2 clear position", n_clr, eblk);
        n_clr++;
      end
      if (op_valid && op_ready) begin
        int bi = eblk / NBJ, bj = eblk % NBJ, ea;
        if (wb_valid) ovl = 1;
        if (!eph) begin
          ea = (bi*SI + eidx)*N + ek;
          check(op_is_b == 1'b0 && int'(op_data) == ea, "R3 A word", int'(op_data), ea);
          if (eidx == SI-1) begin eidx = 0; eph = 1; end else eidx++;
        end else begin
          ea = 1000 + ek*N + bj*SJ + eidx;
          check(op_is_b == 1'b1 && int'(op_data) == ea, "R4 B word", int'(op_data), ea);
          if (eidx == SJ-1) begin
            eidx = 0; eph = 0;
            if (ek == N-1) begin ek = 0; eblk++; end else ek++;
          end else eidx++;
        end
        n_op++;
      end
      if (wb_valid && wb_ready) begin
        int bi = wblk / NBJ, bj = wblk % NBJ, ea;
        ea = (bi*SI + wr)*N + bj*SJ + wc;
        check(int'(wb_addr) == ea, "R6 write-back address", int'(wb_addr), ea);
        check(eblk > wblk, "R6 unload after operands", eblk, wblk + 1);
        if (wc == SJ-1) begin
          wc = 0;
          if (wr == SI-1) begin wr = 0; wblk++; end else wr++;
        end else wc++;
        n_wb++;
      end
      if (done) begin
        n_done++;
        check(n_wb == NB*SI*SJ, "R10 done after last write-back", n_wb, NB*SI*SJ);
        if (tail < 0) tail = 4;
      end
      if (tail == 0) break;
      if (tail > 0) tail--;
    end
    start = 1'b0;
    check(tail == 0, "R10 watchdog", tail, 0);
    check(n_clr == NB, "R5 tile count", n_clr, NB);
    check(n_op == NB*(SI+SJ)*N, "R11 operand words", n_op, NB*(SI+SJ)*N);
    check(n_wb == NB*SI*SJ, "R11 write-back words", n_wb, NB*SI*SJ);
    check(n_done == 1, "R10 single done", n_done, 1);
    if (p[24]) check(ovl, "R9 stream overlaps unload", int'(ovl), 1);
  endtask

  initial begin
    int seen;
    repeat (3) @(negedge clk);
    #1;
    check(!op_valid && !wb_valid && !rd_en && !acc_clr && !done, "R1 reset outputs",
          int'({op_valid, wb_valid, rd_en, acc_clr, done}), 0);
    @(negedge clk); rst_n = 1'b1;
    for (int p = 0; p < NP; p++) run_job(PAT[p]);

    // R9: clear and streaming wait for a free bank
    bank_free = 1'b0; op_ready = 1'b1; wb_ready = 1'b1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    seen = 0;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk); #1;
      if (acc_clr || rd_en || op_valid) seen++;
    end
    check(seen == 0, "R9 withheld bank blocks clear", seen, 0);
    bank_free = 1'b1; #1;
    check(acc_clr == 1'b1, "R9 clear once bank free", int'(acc_clr), 1);
    @(negedge clk); #1;
    check(acc_clr == 1'b0 && rd_en == 1'b1 && rd_sel_b == 1'b0 && rd_addr == '0,
          "R3 first read after clear", int'(rd_addr), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule